// File: doc/BRIEF.md
# CSR Access and Privilege Check Unit

This unit executes control and status register instructions for a small in-order core. A decoded request supplies a 12-bit register address, a two-bit operation code, a source operand, a flag that marks the rs1 field as zero, and the current privilege mode. One cycle later the unit returns the register's previous contents for the destination register. If the access is not allowed, it raises an illegal-instruction fault instead. When a write is due, the addressed register is updated on the same clock edge that captures the request.

Before anything is read, the privilege rule for the addressed register is applied. The address-translation pointer is blocked in user mode. It is also blocked in supervisor mode while the trap-virtual-memory bit of the machine status register is set. The machine status register is reachable only from machine mode. The floating-point control register is not stored as one word. It is a view that combines a five-bit flag register with a three-bit rounding-mode register. A parameterised bank of general registers is read and written directly, with no privilege check.

Top module: `csr_unit`

## Requirements
- R1: After reset, rsp_valid_o and fault_o are low, and every register (translation pointer, machine status, flags, rounding mode, general bank) reads as zero.
- R2: A request with rs1_zero_i high reads the register and never writes it, whatever op_i and operand_i carry.
- R3: Operation codes: 1 stores the operand; 2 stores old OR operand; 3 stores old AND NOT operand; 0 performs a read with no write.
- R4: An access to address 0x180 faults when priv_i is user (0), or when priv_i is supervisor (1) and bit 20 of the machine status register is set. Supervisor with that bit clear, and machine (3), are allowed.
- R5: An access to address 0x300 faults unless priv_i is machine (3).
- R6: Reading address 0x003 returns the flags in bits 4:0 and the rounding mode in bits 7:5. All higher bits read as zero.
- R7: Writing address 0x003 stores data bits 4:0 into the flags and data bits 7:5 into the rounding mode. Higher data bits are dropped.
- R8: The general registers at GEN_BASE (default 0x340) up to GEN_BASE+NUM_GEN-1 are read and written directly from any privilege mode, with no fault.
- R9: A faulting access changes no register, keeps rsp_valid_o low and returns zero on rdata_o.
- R10: Each accepted request produces exactly one of rsp_valid_o or fault_o, in the cycle after it is sampled. Neither output is raised without a request.
- R11: Addresses that match no register read as zero, raise no fault and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| addr_i | input | 12 | CSR address |
| op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| operand_i | input | XLEN | Source operand |
| rs1_zero_i | input | 1 | rs1 field is zero, so the access is read-only |
| priv_i | input | 2 | Current mode: 0 user, 1 supervisor, 3 machine |
| rsp_valid_o | output | 1 | Access completed |
| fault_o | output | 1 | Illegal-instruction fault |
| rdata_o | output | XLEN | Previous register value for rd |

## Verification
Every result appears on the first rising edge after the request is sampled. That edge sets rsp_valid_o or fault_o together with rdata_o, and it also commits any register write, so a request issued on the following cycle already sees the new value. The bench drives each request on a falling edge and samples the outputs shortly after the next rising edge. It withdraws the request before the edge that follows. Register contents are confirmed through later read-only accesses issued from machine mode, so a fault or a suppressed write is checked through the ports in the cycle after the access it follows.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_FCSR    = 3'd1,
    SEL_SATP    = 3'd2,
    SEL_MSTATUS = 3'd3,
    SEL_GEN     = 3'd4
  } csr_sel_e;

  localparam logic [11:0] ADDR_FCSR    = 12'h003;
  localparam logic [11:0] ADDR_SATP    = 12'h180;
  localparam logic [11:0] ADDR_MSTATUS = 12'h300;

  localparam int TVM_BIT  = 20;
  localparam int FFLAGS_W = 5;
  localparam int FRM_W    = 3;
  localparam int FRM_LSB  = FFLAGS_W;
  localparam int FCSR_W   = FFLAGS_W + FRM_W;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_unit_pkg::*;
#(
  parameter logic [11:0] GEN_BASE = 12'h340,
  parameter int          NUM_GEN  = 4,
  localparam int         IDX_W    = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic [11:0]      addr_i,
  output csr_sel_e         sel_o,
  output logic [IDX_W-1:0] gen_idx_o
);

  logic [11:0] offset;
  logic        gen_hit;

  assign offset    = addr_i - GEN_BASE;
  assign gen_hit   = (addr_i >= GEN_BASE) && (offset < 12'(NUM_GEN));
  assign gen_idx_o = offset[IDX_W-1:0];

  always_comb begin
    unique case (addr_i)
      ADDR_FCSR:    sel_o = SEL_FCSR;
      ADDR_SATP:    sel_o = SEL_SATP;
      ADDR_MSTATUS: sel_o = SEL_MSTATUS;
      default:      sel_o = gen_hit ? SEL_GEN : SEL_NONE;
    endcase
  end

endmodule

// File: rtl/csr_priv_check.sv
module csr_priv_check
  import csr_unit_pkg::*;
(
  input  csr_sel_e sel_i,
  input  priv_e    priv_i,
  input  logic     tvm_i,
  output logic     illegal_o
);

  always_comb begin
    illegal_o = 1'b0;
    unique case (sel_i)
      SEL_SATP:    illegal_o = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && tvm_i);
      SEL_MSTATUS: illegal_o = (priv_i != PRIV_M);
      default:     illegal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/csr_alu.sv
module csr_alu
  import csr_unit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op_i,
  input  logic            rs1_zero_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] operand_i,
  output logic [XLEN-1:0] new_o,
  output logic            wr_o
);

  always_comb begin
    unique case (op_i)
      OP_WRITE: new_o = operand_i;
      OP_SET:   new_o = old_i | operand_i;
      OP_CLEAR: new_o = old_i & ~operand_i;
      default:  new_o = old_i;
    endcase
  end

  // rs1 == x0 forces a pure read
  assign wr_o = !rs1_zero_i && (op_i != OP_READ);

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_unit_pkg::*;
#(
  parameter int  XLEN    = 32,
  parameter int  NUM_GEN = 4,
  localparam int IDX_W   = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  csr_sel_e         sel_i,
  input  logic [IDX_W-1:0] gen_idx_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [XLEN-1:0]  rdata_o,
  output logic             tvm_o
);

  logic [XLEN-1:0]     satp_q;
  logic [XLEN-1:0]     mstatus_q;
  logic [FFLAGS_W-1:0] fflags_q;
  logic [FRM_W-1:0]    frm_q;
  logic [XLEN-1:0]     gen_q [NUM_GEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      satp_q <= '0;
    end else if (we_i && sel_i == SEL_SATP) begin
      satp_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mstatus_q <= '0;
    end else if (we_i && sel_i == SEL_MSTATUS) begin
      mstatus_q <= wdata_i;
    end
  end

  // composite view: two independent fields behind one address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fflags_q <= '0;
      frm_q    <= '0;
    end else if (we_i && sel_i == SEL_FCSR) begin
      fflags_q <= wdata_i[FFLAGS_W-1:0];
      frm_q    <= wdata_i[FRM_LSB +: FRM_W];
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gen_q[g] <= '0;
      end else if (we_i && sel_i == SEL_GEN && gen_idx_i == IDX_W'(g)) begin
        gen_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_SATP:    rdata_o = satp_q;
      SEL_MSTATUS: rdata_o = mstatus_q;
      SEL_FCSR:    rdata_o = XLEN'({frm_q, fflags_q});
      SEL_GEN:     rdata_o = gen_q[gen_idx_i];
      default:     rdata_o = '0;
    endcase
  end

  assign tvm_o = mstatus_q[TVM_BIT];

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(satp_q) && $stable(mstatus_q) && $stable(fflags_q) && $stable(frm_q)));

  assert_fcsr_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i != SEL_FCSR) |=> ($stable(fflags_q) && $stable(frm_q)));

endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_unit_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NUM_GEN  = 4,
  parameter logic [11:0] GEN_BASE = 12'h340
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [11:0]     addr_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] operand_i,
  input  logic            rs1_zero_i,
  input  logic [1:0]      priv_i,
  output logic            rsp_valid_o,
  output logic            fault_o,
  output logic [XLEN-1:0] rdata_o
);

  localparam int IDX_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;

  csr_sel_e         sel;
  logic [IDX_W-1:0] gen_idx;
  logic             tvm;
  logic             illegal;
  logic [XLEN-1:0]  old_val;
  logic [XLEN-1:0]  new_val;
  logic             wr_req;
  logic             accept;

  logic             rsp_valid_q;
  logic             fault_q;
  logic [XLEN-1:0]  rdata_q;

  csr_decode #(.GEN_BASE(GEN_BASE), .NUM_GEN(NUM_GEN)) u_decode (
    .addr_i    (addr_i),
    .sel_o     (sel),
    .gen_idx_o (gen_idx)
  );

  csr_priv_check u_priv (
    .sel_i     (sel),
    .priv_i    (priv_e'(priv_i)),
    .tvm_i     (tvm),
    .illegal_o (illegal)
  );

  csr_alu #(.XLEN(XLEN)) u_alu (
    .op_i       (csr_op_e'(op_i)),
    .rs1_zero_i (rs1_zero_i),
    .old_i      (old_val),
    .operand_i  (operand_i),
    .new_o      (new_val),
    .wr_o       (wr_req)
  );

  assign accept = req_valid_i && !illegal;

  csr_regfile #(.XLEN(XLEN), .NUM_GEN(NUM_GEN)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (accept && wr_req),
    .sel_i     (sel),
    .gen_idx_i (gen_idx),
    .wdata_i   (new_val),
    .rdata_o   (old_val),
    .tvm_o     (tvm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      fault_q     <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= accept;
      fault_q     <= req_valid_i && illegal;
      rdata_q     <= accept ? old_val : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign fault_o     = fault_q;
  assign rdata_o     = rdata_q;

  assert_satp_user_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && addr_i == ADDR_SATP && priv_i == PRIV_U) |=> fault_o);

  assert_satp_tvm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && addr_i == ADDR_SATP && priv_i == PRIV_S && tvm) |=> fault_o);

  assert_mstatus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && addr_i == ADDR_MSTATUS && priv_i != PRIV_M) |=> fault_o);

  assert_fcsr_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && addr_i == ADDR_FCSR) |=> ((rdata_o >> FCSR_W) == '0));

  assert_plain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && addr_i == GEN_BASE) |=> rsp_valid_o);

  assert_fault_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (rdata_o == '0));

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && fault_o));

  assert_resp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_valid_o || fault_o));

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !fault_o));

endmodule

// File: tb/sim_csr_unit.sv
module sim_csr_unit;

  localparam int XLEN = 32;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;
  localparam logic [1:0] O_RD = 2'd0, O_WR = 2'd1, O_SET = 2'd2, O_CLR = 2'd3;
  localparam logic [11:0] A_FCSR = 12'h003, A_SATP = 12'h180, A_MST = 12'h300;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [11:0]     addr = '0;
  logic [1:0]      op = '0;
  logic [XLEN-1:0] operand = '0;
  logic            rs1_zero = 1'b0;
  logic [1:0]      priv = '0;
  logic            rsp_valid;
  logic            fault;
  logic [XLEN-1:0] rdata;

  int tests_run = 0;
  int tests_failed = 0;

  logic            got_v;
  logic            got_f;
  logic [XLEN-1:0] got_d;

  always #2 clk = ~clk;

  csr_unit u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .addr_i      (addr),
    .op_i        (op),
    .operand_i   (operand),
    .rs1_zero_i  (rs1_zero),
    .priv_i      (priv),
    .rsp_valid_o (rsp_valid),
    .fault_o     (fault),
    .rdata_o     (rdata)
  );

  task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic [1:0] o, input logic [XLEN-1:0] d,
                        input logic rz, input logic [1:0] p);
    @(negedge clk);
    req_valid = 1'b1; addr = a; op = o; operand = d; rs1_zero = rz; priv = p;
    @(posedge clk);
    #1;
    got_v = rsp_valid; got_f = fault; got_d = rdata;
    req_valid = 1'b0;
  endtask

  task automatic expect_ok(input string req, input logic [XLEN-1:0] exp);
    check(got_v && !got_f && got_d == exp, req, got_d, exp);
  endtask

  task automatic expect_fault(input string req);
    check(!got_v && got_f && got_d == '0, req, {got_v, got_f, got_d[XLEN-3:0]}, {2'b01, 30'h0});
  endtask

  task automatic t_reset;
    check(!rsp_valid && !fault, "R1 outputs idle", {30'h0, rsp_valid, fault}, '0);
    access(A_SATP, O_RD, '0, 1'b1, PM);  expect_ok("R1 satp zero", '0);
    access(A_MST, O_RD, '0, 1'b1, PM);   expect_ok("R1 mstatus zero", '0);
    access(A_FCSR, O_RD, '0, 1'b1, PM);  expect_ok("R1 fcsr zero", '0);
    access(12'h343, O_RD, '0, 1'b1, PM); expect_ok("R1 gen zero", '0);
  endtask

  task automatic t_ops;
    access(12'h341, O_WR, 32'hA5A5_0000, 1'b0, PM);  expect_ok("R3 write old", '0);
    access(12'h341, O_SET, 32'h0000_00FF, 1'b0, PM); expect_ok("R3 set old", 32'hA5A5_0000);
    access(12'h341, O_CLR, 32'h0000_000F, 1'b0, PM); expect_ok("R3 clear old", 32'hA5A5_00FF);
    access(12'h341, O_RD, 32'hFFFF_FFFF, 1'b0, PM);  expect_ok("R3 clear result", 32'hA5A5_00F0);
    access(12'h341, O_RD, '0, 1'b1, PM);             expect_ok("R3 op0 no write", 32'hA5A5_00F0);
  endtask

  task automatic t_readonly;
    access(12'h341, O_WR, 32'h0000_FFFF, 1'b1, PM);  expect_ok("R2 ro write", 32'hA5A5_00F0);
    access(12'h341, O_CLR, 32'hFFFF_FFFF, 1'b1, PM); expect_ok("R2 ro clear", 32'hA5A5_00F0);
    access(12'h341, O_RD, '0, 1'b1, PM);             expect_ok("R2 unchanged", 32'hA5A5_00F0);
  endtask

  task automatic t_satp;
    access(A_SATP, O_WR, 32'h8000_1234, 1'b0, PM);  expect_ok("R4 machine write", '0);
    access(A_SATP, O_RD, '0, 1'b1, PU);             expect_fault("R4 user read");
    access(A_SATP, O_RD, '0, 1'b1, PS);             expect_ok("R4 super tvm0", 32'h8000_1234);
    access(A_MST, O_SET, 32'h0010_0000, 1'b0, PM);  expect_ok("R4 set tvm", '0);
    access(A_SATP, O_WR, 32'h0000_DEAD, 1'b0, PS);  expect_fault("R4 super tvm1");
    access(A_SATP, O_RD, '0, 1'b1, PM);             expect_ok("R9 satp kept", 32'h8000_1234);
    access(A_SATP, O_RD, '0, 1'b1, PM);             expect_ok("R4 machine tvm1", 32'h8000_1234);
  endtask

  task automatic t_mstatus;
    access(A_MST, O_WR, '0, 1'b0, PS);              expect_fault("R5 super");
    access(A_MST, O_CLR, 32'hFFFF_FFFF, 1'b0, PU);  expect_fault("R5 user");
    access(A_MST, O_RD, '0, 1'b1, PM);              expect_ok("R9 mstatus kept", 32'h0010_0000);
    access(A_MST, O_CLR, 32'h0010_0000, 1'b0, PM);  expect_ok("R5 machine", 32'h0010_0000);
    access(A_SATP, O_RD, '0, 1'b1, PS);             expect_ok("R4 super after clear", 32'h8000_1234);
  endtask

  task automatic t_fcsr;
    access(A_FCSR, O_WR, 32'hFFFF_FFFF, 1'b0, PU);  expect_ok("R7 write all", '0);
    access(A_FCSR, O_WR, 32'h0000_00A3, 1'b0, PU);  expect_ok("R6 high bits zero", 32'h0000_00FF);
    access(A_FCSR, O_SET, 32'h0000_0004, 1'b0, PU); expect_ok("R6 frm5 flags3", 32'h0000_00A3);
    access(A_FCSR, O_CLR, 32'h0000_00E0, 1'b0, PU); expect_ok("R7 set flags", 32'h0000_00A7);
    access(A_FCSR, O_RD, '0, 1'b1, PU);             expect_ok("R7 clear frm", 32'h0000_0007);
  endtask

  task automatic t_plain;
    access(12'h342, O_WR, 32'h0000_1234, 1'b0, PU); expect_ok("R8 user write", '0);
    access(12'h342, O_RD, '0, 1'b1, PS);            expect_ok("R8 super read", 32'h0000_1234);
    access(12'h340, O_WR, 32'hCAFE_F00D, 1'b0, PS); expect_ok("R8 base", '0);
    access(12'h340, O_RD, '0, 1'b1, PU);            expect_ok("R8 base read", 32'hCAFE_F00D);
  endtask

  task automatic t_unmapped;
    access(12'h344, O_WR, 32'h1111_1111, 1'b0, PU); expect_ok("R11 past bank", '0);
    access(12'h344, O_RD, '0, 1'b1, PU);            expect_ok("R11 still zero", '0);
    access(12'h7C0, O_SET, 32'hFFFF_FFFF, 1'b0, PM); expect_ok("R11 far address", '0);
    access(12'h343, O_RD, '0, 1'b1, PM);            expect_ok("R11 bank untouched", '0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(posedge clk);
    #1;
    check(!rsp_valid && !fault, "R10 idle", {30'h0, rsp_valid, fault}, '0);
  endtask

  initial begin
    #(4 * 100000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_ops();
    t_readonly();
    t_satp();
    t_mstatus();
    t_fcsr();
    t_plain();
    t_unmapped();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule